// File: doc/BRIEF.md
# I2C Word Access Command Engine

This block sits behind one command word. Software writes a register offset, a 3-bit device number, an opcode and a 16-bit data field into the word. The engine then runs one word-wide access to a target on a small serial bus. It places read results back in the data field and raises a ready flag when it is finished. The serial-line driver is outside the block. The engine reaches it through a simple request/done transfer interface that carries one 16-bit word per transfer.

The bus writes only whole 16-bit words. To change a single byte, software sets a byte-merge bit. The engine then fetches the word at offset+1, takes its low byte as the new upper byte, and writes `{upper, new low byte}` back to the original offset. A watchdog limits how long the engine waits for any one transfer. If the limit expires, the access is abandoned and a timeout flag is raised, so that a poller never hangs.

Top module: `i2c_word_cmd_engine`

## Requirements
- R1: After reset, `ready` is 1, `timeout` is 0, `xfer_req` is 0 and `cmd_rdata` reads 32'h8000_0000.
- R2: Command word layout: data in bits 15:0, register offset in 23:16, device number in 26:24, opcode in 27, byte-merge in 28. `cmd_rdata` returns these fields, with `ready` in bit 31 and bits 30:29 reading 0.
- R3: A `cmd_wr` while `ready` is 1 is accepted. On the next cycle `ready` and `timeout` are 0 and `xfer_req` is 1.
- R4: Opcode 1 runs a single read transfer (`xfer_rd`=1) of the offset, whatever the byte-merge bit holds. The returned word replaces the data field, and its bits 7:0 are the byte-read result.
- R5: Opcode 0 with byte-merge 0 runs a single write transfer (`xfer_rd`=0) of the data field to the offset.
- R6: Opcode 0 with byte-merge 1 first reads offset+1 (modulo 256, so 8'hFF reads 8'h00). It then writes `{read word bits 7:0, data field bits 7:0}` to the offset. Afterwards the data field holds the word that was written.
- R7: `xfer_req` and its fields stay steady until `xfer_done`. `ready` rises on the cycle after the `xfer_done` of the last transfer. `ready` is never 1 while `xfer_req` is 1.
- R8: A `cmd_wr` while `ready` is 0 is ignored. The transfer in flight, the stored fields and the final result are unchanged.
- R9: If `xfer_done` is absent for `TIMEOUT_CYCLES` cycles of one request, the request drops and `ready` and `timeout` go to 1. The data field keeps its value. `timeout` holds until the next accepted command.
- R10: `xfer_dev` carries the device field (bits 26:24). Software fills that field from bits 3:1 of an 8-bit address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Command word readback with ready flag |
| ready | output | 1 | Access finished; engine accepts a command |
| timeout | output | 1 | Last access abandoned by the watchdog |
| xfer_req | output | 1 | Transfer request to the line driver |
| xfer_rd | output | 1 | 1 = read transfer, 0 = write transfer |
| xfer_dev | output | 3 | Target device number |
| xfer_reg | output | 8 | Target register offset |
| xfer_wdata | output | 16 | Word to write |
| xfer_done | input | 1 | One-cycle completion pulse from the driver |
| xfer_rdata | input | 16 | Word read, valid with `xfer_done` |

## Verification
The bench builds the engine with `TIMEOUT_CYCLES` = 20 instead of the default 1000. With that value, an unanswered request can be counted cycle by cycle, and the abort edge can be checked exactly within a short run. The driver model answers after a programmable latency of a few cycles, well under 20. This keeps the merge sequence, with its back-to-back transfers, clear of the watchdog. A longer latency also keeps the engine busy long enough to test a second command write against it.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int CMD_W   = 32;
  localparam int DATA_W  = 16;
  localparam int OFS_W   = 8;
  localparam int DEV_W   = 3;
  localparam int HALF_W  = DATA_W / 2;
  localparam int MRG_BIT = 28;
  localparam int RDY_BIT = 31;

  typedef enum logic [2:0] {
    PH_IDLE, PH_READ, PH_WRITE, PH_MRG_RD, PH_MRG_WR
  } phase_t;

  // Field order matches the command word from bit 28 down to bit 0
  typedef struct packed {
    logic              mrg;
    logic              op;
    logic [DEV_W-1:0]  dev;
    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    return cmd_t'(w[MRG_BIT:0]);
  endfunction

  function automatic logic [CMD_W-1:0] pack_status(input cmd_t c, input logic rdy);
    logic [CMD_W-1:0] p;
    p = '0;
    p[MRG_BIT:0] = c;
    p[RDY_BIT]   = rdy;
    return p;
  endfunction

  function automatic logic [OFS_W-1:0] upper_offset(input logic [OFS_W-1:0] ofs);
    return ofs + OFS_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] merge_word(input logic [HALF_W-1:0] hi,
                                                   input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/i2cw_cmd_reg.sv
module i2cw_cmd_reg
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              load_data,
  input  logic [DATA_W-1:0] data_in,
  input  logic              set_ready,
  input  logic              set_timeout,
  output cmd_t              cur,
  output logic              ready,
  output logic              timeout,
  output logic              accept
);
  assign accept = cmd_wr && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      ready   <= 1'b1;
      timeout <= 1'b0;
    end else if (accept) begin
      cur     <= unpack_cmd(cmd_wdata);
      ready   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (load_data)   cur.data <= data_in;
      if (set_ready)   ready    <= 1'b1;
      if (set_timeout) timeout  <= 1'b1;
    end
  end

  // R3
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cmd_wr));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ready) |=> ($stable(cur.ofs) && $stable(cur.dev) &&
                            $stable(cur.op) && $stable(cur.mrg)));
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cmd_t              new_cmd,
  input  cmd_t              cur,
  input  logic              abort,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_rdata,
  output logic              xfer_req,
  output logic              xfer_rd,
  output logic [OFS_W-1:0]  xfer_reg,
  output logic [DATA_W-1:0] xfer_wdata,
  output logic              finish,
  output logic              merge_step,
  output logic              load_data,
  output logic [DATA_W-1:0] data_in
);
  phase_t            ph;
  phase_t            start_ph;
  logic [HALF_W-1:0] hi_q;
  logic [DATA_W-1:0] merged;

  assign start_ph = new_cmd.op  ? PH_READ :
                    new_cmd.mrg ? PH_MRG_RD : PH_WRITE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      hi_q <= '0;
    end else if (abort) begin
      ph <= PH_IDLE;
    end else if (accept) begin
      ph <= start_ph;
    end else if (xfer_done) begin
      case (ph)
        PH_MRG_RD: begin
          ph   <= PH_MRG_WR;
          hi_q <= xfer_rdata[HALF_W-1:0];
        end
        PH_READ, PH_WRITE, PH_MRG_WR: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign merged     = merge_word(hi_q, cur.data[HALF_W-1:0]);
  assign xfer_req   = (ph != PH_IDLE);
  assign xfer_rd    = (ph == PH_READ) || (ph == PH_MRG_RD);
  assign xfer_reg   = (ph == PH_MRG_RD) ? upper_offset(cur.ofs) : cur.ofs;
  assign xfer_wdata = (ph == PH_MRG_WR) ? merged : cur.data;
  assign merge_step = xfer_done && (ph == PH_MRG_RD);
  assign finish     = xfer_done && ((ph == PH_READ) || (ph == PH_WRITE) ||
                                    (ph == PH_MRG_WR));
  assign load_data  = finish && ((ph == PH_READ) || (ph == PH_MRG_WR));
  assign data_in    = (ph == PH_READ) ? xfer_rdata : merged;

  // R6
  merge_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_step |=> (xfer_req && !xfer_rd));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done && !abort) |=>
      (xfer_req && $stable(xfer_rd) && $stable(xfer_reg) && $stable(xfer_wdata)));
endmodule

// File: rtl/i2cw_watchdog.sv
module i2cw_watchdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic done,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign fire = active && !done && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (!active || done || fire) cnt <= '0;
    else                             cnt <= cnt + CW'(1);
  end

  // R9
  wd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0));
endmodule

// File: rtl/i2c_word_cmd_engine.sv
module i2c_word_cmd_engine
  import i2cw_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic              ready,
  output logic              timeout,
  output logic              xfer_req,
  output logic              xfer_rd,
  output logic [DEV_W-1:0]  xfer_dev,
  output logic [OFS_W-1:0]  xfer_reg,
  output logic [DATA_W-1:0] xfer_wdata,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_rdata
);
  cmd_t              cur;
  logic              accept;
  logic              finish;
  logic              merge_step;
  logic              load_data;
  logic [DATA_W-1:0] data_in;
  logic              wd_fire;

  i2cw_cmd_reg u_reg (
    .clk, .rst_n, .cmd_wr, .cmd_wdata,
    .load_data, .data_in,
    .set_ready(finish || wd_fire), .set_timeout(wd_fire),
    .cur, .ready, .timeout, .accept
  );

  i2cw_seq u_seq (
    .clk, .rst_n, .accept, .new_cmd(unpack_cmd(cmd_wdata)), .cur,
    .abort(wd_fire), .xfer_done, .xfer_rdata,
    .xfer_req, .xfer_rd, .xfer_reg, .xfer_wdata,
    .finish, .merge_step, .load_data, .data_in
  );

  i2cw_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wd (
    .clk, .rst_n, .active(xfer_req), .done(xfer_done), .fire(wd_fire)
  );

  assign xfer_dev  = cur.dev;
  assign cmd_rdata = pack_status(cur, ready);

  // R7
  req_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !ready);

  // R9
  wd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (!xfer_req && ready && timeout));
endmodule

// File: tb/i2c_word_cmd_engine_test.sv
module i2c_word_cmd_engine_test;
  localparam int TO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        ready, timeout, xfer_req, xfer_rd;
  logic [2:0]  xfer_dev;
  logic [7:0]  xfer_reg;
  logic [15:0] xfer_wdata;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_rdata = '0;

  int vectors = 0;
  int misses  = 0;
  bit ended   = 0;

  int lat    = 2;
  bit resp_en = 1;
  int nx = 0;
  logic        lg_rd  [4];
  logic [2:0]  lg_dev [4];
  logic [7:0]  lg_reg [4];
  logic [15:0] lg_wd  [4];

  always #4 clk = ~clk;

  i2c_word_cmd_engine #(.TIMEOUT_CYCLES(TO)) uut (
    .clk, .rst_n, .cmd_wr, .cmd_wdata, .cmd_rdata, .ready, .timeout,
    .xfer_req, .xfer_rd, .xfer_dev, .xfer_reg, .xfer_wdata,
    .xfer_done, .xfer_rdata
  );

  function automatic logic [15:0] model(input logic [2:0] d, input logic [7:0] r);
    return {r ^ 8'h5A, r + {5'b0, d}};
  endfunction

  function automatic logic [31:0] mk(input bit mrg, input bit op, input logic [2:0] d,
                                     input logic [7:0] r, input logic [15:0] dat);
    return {3'b000, mrg, op, d, r, dat};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver model: answers each request after lat cycles and logs it
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req && resp_en) begin
        repeat (lat) @(negedge clk);
        if (nx < 4) begin
          lg_rd[nx] = xfer_rd; lg_dev[nx] = xfer_dev;
          lg_reg[nx] = xfer_reg; lg_wd[nx] = xfer_wdata;
        end
        nx++;
        xfer_rdata = xfer_rd ? model(xfer_dev, xfer_reg) : 16'h0000;
        xfer_done  = 1'b1;
        @(negedge clk);
        xfer_done  = 1'b0;
      end
    end
  end

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", ready, 1);
    chk("R1 timeout", timeout, 0);
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 readback", cmd_rdata, 32'h8000_0000);
  endtask

  task automatic t_read();
    nx = 0; lat = 2;
    issue(mk(0, 1, 3'd5, 8'h3C, 16'h0000));
    chk("R3 ready low", ready, 0);
    chk("R3 timeout low", timeout, 0);
    chk("R3 req high", xfer_req, 1);
    wait_ready();
    chk("R4 count", nx, 1);
    chk("R4 rd", lg_rd[0], 1);
    chk("R10 dev", lg_dev[0], 3'd5);
    chk("R4 reg", lg_reg[0], 8'h3C);
    chk("R2 R4 readback", cmd_rdata, 32'h8000_0000 | mk(0, 1, 5, 8'h3C, 16'h6641));
    chk("R4 byte", cmd_rdata[7:0], 8'h41);
  endtask

  task automatic t_read_mrg();
    nx = 0;
    issue(mk(1, 1, 3'd1, 8'h08, 16'hFFFF));
    wait_ready();
    chk("R4 merge bit ignored count", nx, 1);
    chk("R4 merge bit ignored rd", lg_rd[0], 1);
    chk("R4 merge bit ignored data", cmd_rdata[15:0], model(1, 8'h08));
  endtask

  task automatic t_write();
    nx = 0;
    issue(mk(0, 0, 3'd2, 8'h10, 16'hBEEF));
    wait_ready();
    chk("R5 count", nx, 1);
    chk("R5 rd", lg_rd[0], 0);
    chk("R5 reg", lg_reg[0], 8'h10);
    chk("R5 wdata", lg_wd[0], 16'hBEEF);
    chk("R7 ready", ready, 1);
  endtask

  task automatic t_merge(input logic [2:0] d, input logic [7:0] r, input logic [7:0] lo);
    logic [7:0]  up;
    logic [15:0] w;
    up = r + 8'h01;
    w  = {model(d, up)[7:0], lo};
    nx = 0;
    issue(mk(1, 0, d, r, {8'hC3, lo}));
    wait_ready();
    chk("R6 count", nx, 2);
    chk("R6 first rd", lg_rd[0], 1);
    chk("R6 first reg", lg_reg[0], up);
    chk("R6 second rd", lg_rd[1], 0);
    chk("R6 second reg", lg_reg[1], r);
    chk("R6 second wdata", lg_wd[1], w);
    chk("R6 data field", cmd_rdata[15:0], w);
  endtask

  task automatic t_ignore();
    nx = 0; lat = 8;
    issue(mk(0, 1, 3'd1, 8'h44, 16'h0000));
    issue(mk(0, 0, 3'd6, 8'h99, 16'hAAAA));
    chk("R8 still busy", ready, 0);
    chk("R8 fields kept", cmd_rdata[28:16], mk(0, 1, 1, 8'h44, 0) >> 16);
    wait_ready();
    chk("R8 one transfer", nx, 1);
    chk("R8 reg", lg_reg[0], 8'h44);
    chk("R8 result", cmd_rdata[15:0], model(1, 8'h44));
    lat = 2;
  endtask

  task automatic t_timeout();
    int hi;
    resp_en = 0; nx = 0;
    issue(mk(0, 1, 3'd1, 8'h05, 16'h1234));
    hi = xfer_req ? 1 : 0;
    for (int i = 0; i < 100 && xfer_req; i++) begin
      @(negedge clk);
      if (xfer_req) hi++;
    end
    chk("R9 request length", hi, TO);
    chk("R9 ready", ready, 1);
    chk("R9 timeout", timeout, 1);
    chk("R9 data kept", cmd_rdata[15:0], 16'h1234);
    repeat (3) @(negedge clk);
    chk("R9 timeout holds", timeout, 1);
    resp_en = 1;
    issue(mk(0, 0, 3'd4, 8'h22, 16'h0102));
    chk("R9 timeout cleared", timeout, 0);
    wait_ready();
    chk("R9 recovery", nx, 1);
    chk("R9 recovery timeout", timeout, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_read_mrg();
    t_write();
    t_merge(3'd3, 8'h20, 8'h77);
    t_merge(3'd2, 8'hFF, 8'h5C);
    t_ignore();
    t_timeout();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule